// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns queued characters into asynchronous serial frames on a transmit line. Each frame is a low start bit, then 7, 8 or 9 character positions, then one or two high stop bits. The character length counts the parity bit when parity is on. Parity is generated in hardware. The bit order, the line polarity and which of two pads carries the line can all be set. Besides ordinary characters, the block can send an idle character, which is a whole frame of ones, and a break character, which is a frame period of zeros closed by two stop bits.

Characters come from a store of 9-bit entries. The store acts as an 8-entry FIFO, or as a single holding register when FIFO mode is off. A service request output stays high while the store can take another character. The bit period is set by two counters in series: a prescaler that divides the clock by 1 to 256, then a baud divider. In single-wire half-duplex mode the output enable is dropped whenever no frame is on the line, so the pad is released. A transmit-complete flag rises when a frame ends and nothing is waiting to be sent.

The frame state machine has four states. S_IDLE is the line at rest. S_START is the start bit. S_BITS covers the character positions. S_STOP covers the stop bits. The transitions are: S_IDLE to S_START on launch; S_START to S_BITS on a bit tick; S_BITS to S_STOP on the tick of the last position; S_STOP to S_IDLE at frame end with nothing to send; and S_STOP to S_START at frame end when more work is waiting, which gives back-to-back frames with no gap.

Top module: `sertx_frame_engine`

## Requirements
- R1: A bit lasts exactly (cfg_presc+1)*(cfg_baud+1) clock cycles. The start bit is a logical 0 (except in an idle character), and the line rests at logical 1.
- R2: cfg_len selects the number of character positions: 0 gives 7, 1 gives 8, 2 gives 9, and 3 gives 8.
- R3: With cfg_par_en=1 the last position carries parity over the data bits below it. With cfg_par_odd=0 the total count of ones is even; with cfg_par_odd=1 it is odd.
- R4: cfg_stop2=0 gives one stop bit and cfg_stop2=1 gives two. Stop bits are logical 1, and the line is idle right after them.
- R5: With cfg_msb_first=0, data bit 0 is sent first. With cfg_msb_first=1, the highest data bit is sent first. Parity stays in the last position either way.
- R6: cfg_invert=1 inverts every driven level, including the resting level.
- R7: A pulse on idle_req sends a frame of ones as long as start plus positions plus the configured stop bits.
- R8: A pulse on break_req sends logical 0 for the start bit and all positions, then exactly two stop bits, whatever cfg_stop2 says.
- R9: When several kinds of work are pending, a break goes first, then an idle character, then stored characters.
- R10: With cfg_fifo_en=1 the store holds 8 characters. With cfg_fifo_en=0 it holds 1. Writes to a full store are dropped, and req_o is high exactly when the store is not full.
- R11: tc_o is 0 after reset. It goes to 1 when a frame's last stop bit ends and nothing is waiting, and to 0 when a frame starts.
- R12: With cfg_half_duplex=1 the active pad's enable is 0 whenever no frame is being sent. With cfg_half_duplex=0 it is always 1.
- R13: cfg_swap=0 drives the line on pad index 0 and cfg_swap=1 drives it on pad index 1. The other pad's enable is 0.
- R14: While cfg_en=0 no frame starts, and writes and requests stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Allows frames to start |
| cfg_fifo_en | input | 1 | 1: 8-entry FIFO, 0: single holding register |
| cfg_presc | input | PRESC_W | Prescale divide ratio minus one |
| cfg_baud | input | BAUD_W | Prescaled ticks per bit minus one |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_msb_first | input | 1 | Highest data bit sent first |
| cfg_invert | input | 1 | Line polarity inversion |
| cfg_half_duplex | input | 1 | Release the pad when not sending |
| cfg_swap | input | 1 | Selects which pad carries the line |
| wr_en | input | 1 | Writes wr_data into the store |
| wr_data | input | 9 | Character to send |
| idle_req | input | 1 | Pulse: queue an idle character |
| break_req | input | 1 | Pulse: queue a break character |
| req_o | output | 1 | Store can accept a character |
| tc_o | output | 1 | Transmission complete |
| pad_o | output | 2 | Pad output levels |
| pad_oe | output | 2 | Pad output enables |

## Verification
The hardest situation to reach is a break, an idle character and a stored character all waiting at the same moment, since in normal use each would launch the moment it arrived. The bench holds cfg_en low while it queues all three, checks that the pad stays released, and then enables the block. It captures the three chained frames as one bit stream, which shows both the priority order and the gapless handoff from S_STOP to S_START. The same hold-and-release trick fills the FIFO past its depth, so dropped writes show up as a missing frame at the end of the stream.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CHAR_W = 9;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_BITS  = 2'd2,
        S_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        K_DATA  = 2'd0,
        K_IDLE  = 2'd1,
        K_BREAK = 2'd2
    } frame_kind_e;

    // Number of character positions (parity included) for a length code.
    function automatic logic [3:0] char_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd7;
            2'd2:    return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

    // Arranges a character into transmit order: bit 0 of the result goes out first.
    function automatic logic [CHAR_W-1:0] order_bits(
        input logic [CHAR_W-1:0] d,
        input logic [3:0]        n,
        input logic              par_en,
        input logic              par_odd,
        input logic              msb
    );
        logic [3:0]        nd;
        logic [3:0]        idx;
        logic [CHAR_W-1:0] r;
        logic              p;
        nd = par_en ? (n - 4'd1) : n;
        r  = '0;
        p  = par_odd;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < int'(nd)) begin
                idx = msb ? 4'(int'(nd) - 1 - i) : 4'(i);
                r[4'(i)] = d[idx];
                p = p ^ d[4'(i)];
            end
        end
        if (par_en) r[n - 4'd1] = p;
        return r;
    endfunction

endpackage

// File: rtl/sertx_bit_clock.sv
module sertx_bit_clock #(
    parameter int PRESC_W = 8,
    parameter int BAUD_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc_div,
    input  logic [BAUD_W-1:0]  baud_div,
    output logic               bit_tick
);
    logic [PRESC_W-1:0] pcnt_q;
    logic [BAUD_W-1:0]  bcnt_q;
    logic               pre_tick;

    assign pre_tick = (pcnt_q == presc_div);
    assign bit_tick = pre_tick && (bcnt_q == baud_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            bcnt_q <= '0;
        end else if (restart) begin
            pcnt_q <= '0;
            bcnt_q <= '0;
        end else begin
            pcnt_q <= pre_tick ? '0 : pcnt_q + 1'b1;
            if (pre_tick) bcnt_q <= bit_tick ? '0 : bcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sertx_char_store.sv
module sertx_char_store #(
    parameter int DEPTH = 8,
    parameter int W     = 9,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          pop,
    output logic [W-1:0]  rd_data,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] count_q, cap;
    logic          push, take;

    assign cap     = fifo_en ? CW'(DEPTH) : CW'(1);
    assign full    = (count_q >= cap);
    assign empty   = (count_q == '0);
    assign push    = wr_en && !full;
    assign take    = pop && !empty;
    assign rd_data = mem[rd_ptr_q];
    assign level   = count_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr_q] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (take) rd_ptr_q <= bump(rd_ptr_q);
            if (push && !take)      count_q <= count_q + 1'b1;
            else if (take && !push) count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/sertx_frame_fsm.sv
module sertx_frame_fsm
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_tick,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic              cfg_msb_first,
    input  logic              idle_req,
    input  logic              break_req,
    input  logic              have_char,
    input  logic [CHAR_W-1:0] char_data,
    output logic              char_pop,
    output logic              restart,
    output logic              line_lvl,
    output logic              tc,
    output tx_state_e         state_o
);
    tx_state_e         state_q, state_d;
    frame_kind_e       kind_q, kind_sel;
    logic [CHAR_W-1:0] shift_q;
    logic [3:0]        nbits_q, bit_idx_q;
    logic              extra_stop_q;
    logic              idle_pend_q, break_pend_q;
    logic              work, last_bit, frame_end, launch;

    // Work selection: break before idle before stored characters (R9).
    always_comb begin
        kind_sel = K_DATA;
        work     = 1'b1;
        if (break_pend_q)     kind_sel = K_BREAK;
        else if (idle_pend_q) kind_sel = K_IDLE;
        else if (!have_char)  work     = 1'b0;
    end

    assign last_bit  = (bit_idx_q == nbits_q - 4'd1);
    assign frame_end = (state_q == S_STOP) && bit_tick && !extra_stop_q;
    assign launch    = en && work && ((state_q == S_IDLE) || frame_end);
    assign char_pop  = launch && (kind_sel == K_DATA);
    assign restart   = launch;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (launch) state_d = S_START;
            S_START: if (bit_tick) state_d = S_BITS;
            S_BITS:  if (bit_tick && last_bit) state_d = S_STOP;
            S_STOP:  if (frame_end) state_d = launch ? S_START : S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q       <= K_DATA;
            shift_q      <= '0;
            nbits_q      <= 4'd8;
            bit_idx_q    <= '0;
            extra_stop_q <= 1'b0;
        end else if (launch) begin
            kind_q       <= kind_sel;
            nbits_q      <= char_bits(cfg_len);
            bit_idx_q    <= '0;
            extra_stop_q <= cfg_stop2 || (kind_sel == K_BREAK);
            case (kind_sel)
                K_BREAK: shift_q <= '0;
                K_IDLE:  shift_q <= '1;
                default: shift_q <= order_bits(char_data, char_bits(cfg_len),
                                               cfg_par_en, cfg_par_odd, cfg_msb_first);
            endcase
        end else if (bit_tick) begin
            if (state_q == S_BITS) begin
                shift_q   <= shift_q >> 1;
                bit_idx_q <= bit_idx_q + 4'd1;
            end else if (state_q == S_STOP && extra_stop_q) begin
                extra_stop_q <= 1'b0;
            end
        end
    end

    // Pending special characters and completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_pend_q  <= 1'b0;
            break_pend_q <= 1'b0;
            tc           <= 1'b0;
        end else begin
            break_pend_q <= (break_pend_q && !(launch && kind_sel == K_BREAK)) || break_req;
            idle_pend_q  <= (idle_pend_q && !(launch && kind_sel == K_IDLE)) || idle_req;
            if (launch)         tc <= 1'b0;
            else if (frame_end) tc <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        line_lvl = 1'b1;
        unique case (state_q)
            S_IDLE:  line_lvl = 1'b1;
            S_START: line_lvl = (kind_q == K_IDLE);
            S_BITS:  line_lvl = shift_q[0];
            S_STOP:  line_lvl = 1'b1;
        endcase
        state_o = state_q;
    end
endmodule

// File: rtl/sertx_frame_engine.sv
module sertx_frame_engine
    import sertx_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int PRESC_W = 8,
    parameter int BAUD_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_fifo_en,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [BAUD_W-1:0]  cfg_baud,
    input  logic [1:0]         cfg_len,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic               cfg_stop2,
    input  logic               cfg_msb_first,
    input  logic               cfg_invert,
    input  logic               cfg_half_duplex,
    input  logic               cfg_swap,
    input  logic               wr_en,
    input  logic [CHAR_W-1:0]  wr_data,
    input  logic               idle_req,
    input  logic               break_req,
    output logic               req_o,
    output logic               tc_o,
    output logic [1:0]         pad_o,
    output logic [1:0]         pad_oe
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [CHAR_W-1:0] char_data;
    logic              store_empty, store_full, char_pop;
    logic [LVL_W-1:0]  store_level;
    logic              bit_tick, restart, line_lvl;
    logic              line_drive, drive_en;
    tx_state_e         fsm_state;

    sertx_char_store #(.DEPTH(DEPTH), .W(CHAR_W)) store_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en),
        .wr_en(wr_en), .wr_data(wr_data), .pop(char_pop),
        .rd_data(char_data), .empty(store_empty), .full(store_full),
        .level(store_level)
    );

    sertx_bit_clock #(.PRESC_W(PRESC_W), .BAUD_W(BAUD_W)) clock_i (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .presc_div(cfg_presc), .baud_div(cfg_baud), .bit_tick(bit_tick)
    );

    sertx_frame_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .bit_tick(bit_tick),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_msb_first(cfg_msb_first),
        .idle_req(idle_req), .break_req(break_req),
        .have_char(!store_empty), .char_data(char_data),
        .char_pop(char_pop), .restart(restart), .line_lvl(line_lvl),
        .tc(tc_o), .state_o(fsm_state)
    );

    assign req_o      = !store_full;
    assign line_drive = line_lvl ^ cfg_invert;
    assign drive_en   = cfg_half_duplex ? (fsm_state != S_IDLE) : 1'b1;

    for (genvar p = 0; p < 2; p++) begin : g_pad
        assign pad_o[p]  = (cfg_swap == 1'(p)) ? line_drive : 1'b0;
        assign pad_oe[p] = (cfg_swap == 1'(p)) ? drive_en   : 1'b0;
    end
endmodule

// File: rtl/sertx_frame_checker.sv
module sertx_frame_checker
    import sertx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_half_duplex,
    input tx_state_e        fsm_state,
    input logic             bit_tick,
    input logic             line_lvl,
    input logic             char_pop,
    input logic [LVL_W-1:0] store_level,
    input logic             tc_o,
    input logic [1:0]       pad_oe
);
    // R1: a stored character starts with a low start bit
    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        char_pop |=> (line_lvl == 1'b0));

    // R1: the line level only moves on a bit boundary
    assert_hold_between_ticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_state != S_IDLE) && ($past(fsm_state) != S_IDLE) && !$past(bit_tick))
        |-> $stable(line_lvl));

    // R10: the store never holds more than its depth
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        store_level <= LVL_W'(DEPTH));

    // R11: completion only while the line is at rest
    assert_tc_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> (fsm_state == S_IDLE));

    // R12: half-duplex pad released when no frame runs
    assert_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_half_duplex && fsm_state == S_IDLE) |-> (pad_oe == 2'b00));

    // R13: at most one pad driven
    assert_one_pad_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pad_oe));
endmodule

bind sertx_frame_engine sertx_frame_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_half_duplex(cfg_half_duplex),
    .fsm_state(fsm_state), .bit_tick(bit_tick), .line_lvl(line_lvl),
    .char_pop(char_pop), .store_level(store_level), .tc_o(tc_o), .pad_oe(pad_oe)
);

// File: tb/sertx_frame_engine_tb_top.sv
module sertx_frame_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_fifo_en = 1'b0;
    logic [7:0]  cfg_presc = 8'd1;
    logic [11:0] cfg_baud = 12'd3;
    logic [1:0]  cfg_len = 2'd1;
    logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic        cfg_msb_first = 1'b0, cfg_invert = 1'b0;
    logic        cfg_half_duplex = 1'b0, cfg_swap = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_data = '0;
    logic        idle_req = 1'b0, break_req = 1'b0;
    logic        req_o, tc_o;
    logic [1:0]  pad_o, pad_oe;

    int n_checks = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sertx_frame_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_fifo_en(cfg_fifo_en),
        .cfg_presc(cfg_presc), .cfg_baud(cfg_baud), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
        .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
        .cfg_half_duplex(cfg_half_duplex), .cfg_swap(cfg_swap),
        .wr_en(wr_en), .wr_data(wr_data), .idle_req(idle_req), .break_req(break_req),
        .req_o(req_o), .tc_o(tc_o), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    // Stimulus table: {data[8:0], len[1:0], par, odd, stop2, msb, inv}
    localparam logic [15:0] VEC [6] = '{
        {9'h0A5, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {9'h1A5, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {9'h055, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {9'h0C3, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {9'h0F0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {9'h13C, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    function automatic int npos(input logic [1:0] c);
        return (c == 2'd0) ? 7 : (c == 2'd2) ? 9 : 8;
    endfunction

    function automatic int flen(input logic [1:0] c, input logic stop2);
        return 1 + npos(c) + (stop2 ? 2 : 1);
    endfunction

    // Expected frame from the requirements; bit 0 is first on the line, unused bits are 1.
    function automatic logic [127:0] fexp(input logic [8:0] d, input logic [1:0] c,
                                          input logic par, input logic odd, input logic msb);
        logic [127:0] r;
        int n, nd;
        logic p;
        r = '1;
        r[0] = 1'b0;
        n = npos(c);
        nd = par ? n - 1 : n;
        p = odd;
        for (int i = 0; i < nd; i++) begin
            r[1 + i] = msb ? d[nd - 1 - i] : d[i];
            p = p ^ d[i];
        end
        if (par) r[n] = p;
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_char(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Waits for the pad to be driven, then samples nb bits at mid-bit.
    // Returns at mid of the bit position after the last one.
    task automatic capture(input int nb, input int k, input logic inv,
                           output logic [127:0] bits, output logic tc_start);
        bit seen;
        bits = '1;
        seen = 1'b0;
        tc_start = 1'b1;
        for (int t = 0; t < 4000 && !seen; t++) begin
            @(negedge clk);
            if (pad_oe[0]) seen = 1'b1;
        end
        if (seen) begin
            repeat (k / 2) @(negedge clk);
            tc_start = tc_o;
            for (int j = 0; j < nb; j++) begin
                bits[j] = pad_o[0] ^ inv;
                repeat (k) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] got, exp;
        logic         tcs;
        int           pos;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check(tc_o == 1'b0, "R11 tc after reset", 128'(tc_o), 128'd0);
        check(req_o == 1'b1, "R10 req after reset", 128'(req_o), 128'd1);
        check(pad_oe == 2'b01, "R12 full-duplex enable", 128'(pad_oe), 128'd1);
        check(pad_o[0] == 1'b1, "R1 resting level", 128'(pad_o[0]), 128'd1);

        // Pad swap and polarity at rest
        cfg_swap = 1'b1;
        @(negedge clk);
        check(pad_oe == 2'b10, "R13 swapped enables", 128'(pad_oe), 128'd2);
        check(pad_o[1] == 1'b1, "R13 swapped line level", 128'(pad_o[1]), 128'd1);
        cfg_swap = 1'b0;
        cfg_invert = 1'b1;
        @(negedge clk);
        check(pad_o[0] == 1'b0, "R6 inverted rest level", 128'(pad_o[0]), 128'd0);
        cfg_invert = 1'b0;
        cfg_half_duplex = 1'b1;
        @(negedge clk);
        check(pad_oe == 2'b00, "R12 released when idle", 128'(pad_oe), 128'd0);
        cfg_en = 1'b1;

        // Table of frame formats
        for (int v = 0; v < 6; v++) begin
            logic [8:0] d;
            d = VEC[v][15:7];
            cfg_len = VEC[v][6:5];
            cfg_par_en = VEC[v][4];
            cfg_par_odd = VEC[v][3];
            cfg_stop2 = VEC[v][2];
            cfg_msb_first = VEC[v][1];
            cfg_invert = VEC[v][0];
            write_char(d);
            capture(flen(cfg_len, cfg_stop2), 8, cfg_invert, got, tcs);
            exp = fexp(d, cfg_len, cfg_par_en, cfg_par_odd, cfg_msb_first);
            check(got == exp, "R2/R3/R4/R5/R6 frame bits", got, exp);
            check(tcs == 1'b0, "R11 tc cleared in frame", 128'(tcs), 128'd0);
            check(pad_oe[0] == 1'b0, "R4 frame ends after stop bits", 128'(pad_oe[0]), 128'd0);
            check(tc_o == 1'b1, "R11 tc after frame", 128'(tc_o), 128'd1);
        end
        cfg_invert = 1'b0;

        // Different bit period: 3 x 2 = 6 clocks per bit
        cfg_presc = 8'd2;
        cfg_baud = 12'd1;
        cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_stop2 = 1'b0; cfg_msb_first = 1'b0;
        write_char(9'h03C);
        capture(10, 6, 1'b0, got, tcs);
        exp = fexp(9'h03C, 2'd1, 1'b0, 1'b0, 1'b0);
        check(got == exp, "R1 bit period with prescaler", got, exp);
        check(pad_oe[0] == 1'b0, "R1 frame length in clocks", 128'(pad_oe[0]), 128'd0);
        cfg_presc = 8'd1;
        cfg_baud = 12'd3;

        // Idle character: 7 positions, two stops -> 10 ones
        cfg_len = 2'd0; cfg_stop2 = 1'b1;
        @(negedge clk); idle_req = 1'b1; @(negedge clk); idle_req = 1'b0;
        capture(10, 8, 1'b0, got, tcs);
        check(got == '1, "R7 idle frame all ones", got, '1);
        check(pad_oe[0] == 1'b0, "R7 idle frame length", 128'(pad_oe[0]), 128'd0);

        // Priority with enable held low, then chained frames
        cfg_len = 2'd1; cfg_stop2 = 1'b0;
        cfg_en = 1'b0;
        write_char(9'h05A);
        @(negedge clk); idle_req = 1'b1; @(negedge clk); idle_req = 1'b0;
        @(negedge clk); break_req = 1'b1; @(negedge clk); break_req = 1'b0;
        repeat (40) @(negedge clk);
        check(pad_oe[0] == 1'b0, "R14 no frame while disabled", 128'(pad_oe[0]), 128'd0);
        cfg_en = 1'b1;
        capture(31, 8, 1'b0, got, tcs);
        exp = '1;
        for (int j = 0; j < 9; j++) exp[j] = 1'b0;
        pos = 21;
        begin
            logic [127:0] f;
            f = fexp(9'h05A, 2'd1, 1'b0, 1'b0, 1'b0);
            for (int j = 0; j < 10; j++) exp[pos + j] = f[j];
        end
        check(got == exp, "R8/R9 break, idle, data order", got, exp);
        check(pad_oe[0] == 1'b0, "R8 break stop count", 128'(pad_oe[0]), 128'd0);

        // FIFO mode: 10 writes, 8 kept
        cfg_fifo_en = 1'b1;
        cfg_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            write_char(9'((i * 37 + 11) & 9'h0FF));
            if (i == 6) check(req_o == 1'b1, "R10 req with room", 128'(req_o), 128'd1);
        end
        check(req_o == 1'b0, "R10 req when full", 128'(req_o), 128'd0);
        cfg_en = 1'b1;
        capture(80, 8, 1'b0, got, tcs);
        exp = '1;
        for (int i = 0; i < 8; i++) begin
            logic [127:0] f;
            f = fexp(9'((i * 37 + 11) & 9'h0FF), 2'd1, 1'b0, 1'b0, 1'b0);
            for (int j = 0; j < 10; j++) exp[i * 10 + j] = f[j];
        end
        check(got == exp, "R10 eight queued frames", got, exp);
        check(pad_oe[0] == 1'b0, "R10 overflow writes dropped", 128'(pad_oe[0]), 128'd0);

        // Single holding register
        cfg_fifo_en = 1'b0;
        cfg_en = 1'b0;
        write_char(9'h0E1);
        check(req_o == 1'b0, "R10 buffer full after one", 128'(req_o), 128'd0);
        write_char(9'h01E);
        cfg_en = 1'b1;
        capture(10, 8, 1'b0, got, tcs);
        exp = fexp(9'h0E1, 2'd1, 1'b0, 1'b0, 1'b0);
        check(got == exp, "R10 buffer keeps first", got, exp);
        check(pad_oe[0] == 1'b0, "R10 buffer drops second", 128'(pad_oe[0]), 128'd0);
        check(req_o == 1'b1, "R10 req after drain", 128'(req_o), 128'd1);

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule